// File: doc/BRIEF.md
# Input Pin Edge Interrupt Controller

This block watches eight already-filtered input levels and turns a chosen transition on each one into a sticky pending flag. Software programs it through a small register window. Each pin has its own edge-direction bit and its own enable bit. A shared two-bit priority field covers all pins. A write-one-to-clear flag register shows which pins have seen their edge.

The block raises a single request toward the CPU when two conditions hold. First, at least one pin must have both its flag and its enable set. Second, the shared priority must be strictly above the CPU's current two-bit mask level. While the request is raised, the block also drives the priority level that the request carries. A flag latches whenever its edge occurs, whatever the enable and priority settings are. Software can therefore poll pins that it has not enabled.

Top module: `kin_irq_ctrl`

## Requirements
- R1: After reset the polarity register (address 0) reads 8'hFF, the enable register (address 1) reads 8'h00, the flag register (address 2) reads 8'h00, the priority register (address 3) reads 8'h00, and irq_req and irq_level are 0.
- R2: Polarity bit i selects the edge for pin i. A 1 selects a falling edge (previous level 1, present level 0) and a 0 selects a rising edge. Only the selected edge sets flag bit i, which reads as 1 from the clock edge that samples the new level onward.
- R3: A flag bit is set by its selected edge whatever the enable bits, the priority field and cpu_mask hold.
- R4: Writing to address 2 clears every flag bit whose wdata bit is 1. Flag bits whose wdata bit is 0 are left unchanged.
- R5: The priority field is wdata[1:0] at address 3, with 00 meaning no interrupt and 01, 10 and 11 meaning levels 1, 2 and 3. It reads back in rdata[1:0], with the upper bits 0. irq_level equals the field while irq_req is 1, and is 00 otherwise.
- R6: irq_req is 1 exactly when (flags AND enables) is nonzero and the priority field is strictly greater than cpu_mask. It is combinational from the register state and cpu_mask.
- R7: The polarity and enable registers read back the last value written to them. rdata is combinational from addr.
- R8: An input change seen at the first clock edge after reset is released sets no flag.
- R9: When an edge and a write-1 clear hit the same flag bit in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | 8 | Filtered input levels, one per pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 polarity, 1 enable, 2 flags, 3 priority |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| cpu_mask | input | 2 | CPU's current interrupt mask level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 2 | Priority level of the active request |

## Verification
A corrupted edge history or polarity bit shows up as a flag that reads wrongly at address 2. This appears at the negedge right after the clock edge that sampled the new pin level, so every single-pin toggle in the sweep exposes it within one cycle. A wrong enable, priority or compare shows at irq_req and irq_level in the same cycle that cpu_mask or the register changes, and the full four-by-four priority-versus-mask grid exposes it. Three further faults each show in the flag register one cycle after their stimulus: a dropped clear, an over-eager clear, and a clear that beats a simultaneous edge.

// File: rtl/kin_irq_pkg.sv
package kin_irq_pkg;

    localparam int PRIO_W = 2;
    localparam int ADDR_W = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_POLARITY = 2'd0,
        SEL_ENABLE   = 2'd1,
        SEL_FLAGS    = 2'd2,
        SEL_PRIORITY = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic  req;
        prio_t level;
    } irq_out_t;

    // Priority wins only when strictly above the CPU mask level.
    function automatic logic prio_beats(prio_t prio, prio_t mask);
        return prio > mask;
    endfunction

endpackage

// File: rtl/kin_edge_detect.sv
module kin_edge_detect #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] polarity,
    output logic [NUM_PINS-1:0] edge_hit
);

    logic [NUM_PINS-1:0] prev_level;
    logic                armed;

    // History tracks the pins even in reset; armed blocks the first compare.
    always_ff @(posedge clk) begin
        prev_level <= pin_level;
        if (rst) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            logic rise;
            logic fall;
            assign rise        = ~prev_level[i] &  pin_level[i];
            assign fall        =  prev_level[i] & ~pin_level[i];
            assign edge_hit[i] = armed & (polarity[i] ? fall : rise);
        end
    endgenerate

endmodule

// File: rtl/kin_reg_file.sv
module kin_reg_file
    import kin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic [NUM_PINS-1:0] edge_hit,
    output logic [NUM_PINS-1:0] polarity_q,
    output logic [NUM_PINS-1:0] enable_q,
    output logic [NUM_PINS-1:0] flag_q,
    output prio_t               prio_q,
    output logic [NUM_PINS-1:0] rdata
);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] flag_d;

    assign sel     = reg_sel_e'(addr);
    assign clr_vec = (wr_en && sel == SEL_FLAGS) ? wdata : '0;
    // An edge in the same cycle as a clear keeps the flag set.
    assign flag_d  = (flag_q & ~clr_vec) | edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            polarity_q <= '1;
            enable_q   <= '0;
            flag_q     <= '0;
            prio_q     <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_en) begin
                case (sel)
                    SEL_POLARITY: polarity_q <= wdata;
                    SEL_ENABLE:   enable_q   <= wdata;
                    SEL_PRIORITY: prio_q     <= wdata[PRIO_W-1:0];
                    default:      ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_POLARITY: rdata = polarity_q;
            SEL_ENABLE:   rdata = enable_q;
            SEL_FLAGS:    rdata = flag_q;
            default:      rdata = {{(NUM_PINS-PRIO_W){1'b0}}, prio_q};
        endcase
    end

endmodule

// File: rtl/kin_irq_arb.sv
module kin_irq_arb
    import kin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] flag_q,
    input  logic [NUM_PINS-1:0] enable_q,
    input  prio_t               prio_q,
    input  prio_t               cpu_mask,
    output irq_out_t            irq_out
);

    logic pending;

    assign pending       = |(flag_q & enable_q);
    assign irq_out.req   = pending & prio_beats(prio_q, cpu_mask);
    assign irq_out.level = irq_out.req ? prio_q : '0;

endmodule

// File: rtl/kin_irq_ctrl.sv
module kin_irq_ctrl
    import kin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    input  logic [PRIO_W-1:0]   cpu_mask,
    output logic                irq_req,
    output logic [PRIO_W-1:0]   irq_level
);

    logic [NUM_PINS-1:0] polarity_q;
    logic [NUM_PINS-1:0] enable_q;
    logic [NUM_PINS-1:0] flag_q;
    logic [NUM_PINS-1:0] edge_hit;
    prio_t               prio_q;
    irq_out_t            irq_out;

    kin_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin_level),
        .polarity  (polarity_q),
        .edge_hit  (edge_hit)
    );

    kin_reg_file #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .edge_hit   (edge_hit),
        .polarity_q (polarity_q),
        .enable_q   (enable_q),
        .flag_q     (flag_q),
        .prio_q     (prio_q),
        .rdata      (rdata)
    );

    kin_irq_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .flag_q   (flag_q),
        .enable_q (enable_q),
        .prio_q   (prio_q),
        .cpu_mask (cpu_mask),
        .irq_out  (irq_out)
    );

    assign irq_req   = irq_out.req;
    assign irq_level = irq_out.level;

endmodule

// File: rtl/kin_irq_checker.sv
module kin_irq_checker
    import kin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_PINS-1:0] wdata,
    input logic [PRIO_W-1:0]   cpu_mask,
    input logic                irq_req,
    input logic [PRIO_W-1:0]   irq_level,
    input logic [NUM_PINS-1:0] flag_q,
    input logic [NUM_PINS-1:0] enable_q,
    input logic [PRIO_W-1:0]   prio_q,
    input logic [NUM_PINS-1:0] edge_hit
);

    logic [NUM_PINS-1:0] clr_port;
    assign clr_port = (wr_en && addr == SEL_FLAGS) ? wdata : '0;

    // R4: a set flag stays set unless a 1 was written to it.
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(flag_q) & ~$past(clr_port)) & ~flag_q) == '0));

    // R3 and R9: every reported edge leaves its flag set, clear or not.
    assert_edge_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(edge_hit) & ~flag_q) == '0));

    // R6: a request needs an enabled pending flag and a winning priority.
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((flag_q & enable_q) != '0) && (prio_q > cpu_mask));

    // R5: a nonzero level is only driven alongside a request.
    assert_level_with_req_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (irq_req && irq_level == prio_q));

    // R8: nothing is flagged by the first compare after reset.
    assert_no_first_edge_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rst, 2) && !$past(rst)) |-> (flag_q == '0));

endmodule

bind kin_irq_ctrl kin_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .cpu_mask  (cpu_mask),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .flag_q    (flag_q),
    .enable_q  (enable_q),
    .prio_q    (prio_q),
    .edge_hit  (edge_hit)
);

// File: tb/kin_irq_ctrl_tb.sv
module kin_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_level = 8'hFF;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] cpu_mask = 2'd0;
    logic       irq_req;
    logic [1:0] irq_level;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_flags;
    logic [7:0] exp_pol;
    logic [7:0] prev_pins;

    always #4 clk = ~clk;

    kin_irq_ctrl #(.NUM_PINS(8)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin_level),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .cpu_mask  (cpu_mask),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    // Apply new pin levels; model the flags from the polarity rule.
    task automatic drive_pins(input logic [7:0] v);
        logic [7:0] rise;
        logic [7:0] fall;
        @(negedge clk);
        pin_level = v;
        rise = ~prev_pins & v;
        fall = prev_pins & ~v;
        exp_flags = exp_flags | (exp_pol & fall) | (~exp_pol & rise);
        prev_pins = v;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: pins fall at the very first edge after reset is released.
        rst = 1'b0;
        pin_level = 8'h00;
        @(negedge clk);
        rd_check("R8 flags after first cycle", 2'd2, 8'h00);
        @(negedge clk);
        rd_check("R8 flags second cycle", 2'd2, 8'h00);
        // R1 reset values
        rd_check("R1 polarity reset", 2'd0, 8'hFF);
        rd_check("R1 enable reset", 2'd1, 8'h00);
        rd_check("R1 flags reset", 2'd2, 8'h00);
        rd_check("R1 priority reset", 2'd3, 8'h00);
        check("R1 irq_req reset", {7'd0, irq_req}, 8'h00);
        check("R1 irq_level reset", {6'd0, irq_level}, 8'h00);

        prev_pins = 8'h00;
        exp_flags = 8'h00;
        exp_pol = 8'hFF;

        // R7 readback
        wr(2'd0, 8'h5A);
        rd_check("R7 polarity readback", 2'd0, 8'h5A);
        wr(2'd1, 8'hC3);
        rd_check("R7 enable readback", 2'd1, 8'hC3);
        wr(2'd1, 8'h00);
        rd_check("R7 enable readback zero", 2'd1, 8'h00);

        // R2/R3 sweep: several polarity patterns, single toggles and groups,
        // with enables off and priority at maximum.
        wr(2'd3, 8'h03);
        cpu_mask = 2'd0;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] pol_pat;
            pol_pat = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : (p == 2) ? 8'hA5 : 8'h3C;
            wr(2'd0, pol_pat);
            exp_pol = pol_pat;
            wr(2'd2, 8'hFF);
            exp_flags = 8'h00;
            rd_check("R4 clear all before sweep", 2'd2, 8'h00);
            for (int i = 0; i < 8; i++) begin
                drive_pins(prev_pins ^ (8'h01 << i));
                rd_check("R2 flag after toggle on", 2'd2, exp_flags);
                drive_pins(prev_pins ^ (8'h01 << i));
                rd_check("R2 flag after toggle off", 2'd2, exp_flags);
                check("R3 no request with enables off", {7'd0, irq_req}, 8'h00);
            end
            wr(2'd2, 8'hFF);
            exp_flags = 8'h00;
            drive_pins(8'hFF);
            rd_check("R2 group rise", 2'd2, exp_flags);
            drive_pins(8'h0F);
            rd_check("R2 group mixed", 2'd2, exp_flags);
            drive_pins(8'h00);
            rd_check("R2 group fall", 2'd2, exp_flags);
        end

        // R4 selective clearing (flags now all set after the group steps)
        wr(2'd0, 8'hFF); exp_pol = 8'hFF;
        wr(2'd2, 8'hFF); exp_flags = 8'h00;
        drive_pins(8'hFF);
        drive_pins(8'h00);
        rd_check("R4 all flags set", 2'd2, 8'hFF);
        wr(2'd2, 8'h00);
        rd_check("R4 write zero keeps flags", 2'd2, 8'hFF);
        wr(2'd2, 8'h96);
        rd_check("R4 write ones clears selected", 2'd2, 8'h69);
        exp_flags = 8'h69;

        // R5/R6: priority versus mask grid with pin 0 pending and enabled
        wr(2'd1, 8'h01);
        for (int pr = 0; pr < 4; pr++) begin
            wr(2'd3, 8'hFC | pr[7:0]);
            rd_check("R5 priority readback", 2'd3, pr[7:0]);
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                cpu_mask = m[1:0];
                #1;
                check("R6 irq_req grid", {7'd0, irq_req}, (pr > m) ? 8'h01 : 8'h00);
                check("R5 irq_level grid", {6'd0, irq_level}, (pr > m) ? pr[7:0] : 8'h00);
            end
        end

        // R6: enabled pin without a flag gives no request
        cpu_mask = 2'd0;
        wr(2'd1, 8'h02);
        #1;
        check("R6 enable without flag", {7'd0, irq_req}, 8'h00);
        wr(2'd1, 8'h08);
        #1;
        check("R6 enable with flag", {7'd0, irq_req}, 8'h01);
        wr(2'd2, 8'h08);
        #1;
        check("R6 request drops after clear", {7'd0, irq_req}, 8'h00);
        check("R5 level drops after clear", {6'd0, irq_level}, 8'h00);

        // R9: edge and clear in the same cycle on pin 2, clear-all written
        wr(2'd2, 8'hFF);
        @(negedge clk);
        pin_level = 8'h04;
        @(negedge clk);
        pin_level = 8'h00;
        wr_en = 1'b1; addr = 2'd2; wdata = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check("R9 set wins over clear", 2'd2, 8'h04);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule